// File: doc/BRIEF.md
# Quadrature Carrier Correlator Downconverter

This block takes real, signed samples of a BPSK carrier that was sampled directly at 250 kHz. It turns them into baseband in-phase (I) and quadrature (Q) streams. The carrier sits at 4/19 of the sample rate, which is about 52.63 kHz. Its period is 19 µs, and 19 samples hold exactly four carrier periods.

For each arm, the block keeps a 19-sample window of input. It correlates the window against a 19-entry cosine reference (I arm) and a 19-entry sine reference (Q arm). That costs 38 multiply-accumulates per sample. The reference pattern circulates in step with the window, so each product uses the phase of the sample's own arrival. Because the window spans whole carrier periods, the double-frequency term cancels. A 19-point running sum then smooths each arm further.

Both arms are always produced, because a single-phase product can vanish for some carrier phase offsets. Carrier phase tracking and bit decisions belong to the logic downstream.

Both stream edges use valid/ready:
- A sample transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers where `out_valid` and `out_ready` are both high.
- The sender may drop `in_valid` at any time.
- While `out_valid` is high and `out_ready` is low, the result on the outputs is held unchanged.
- The block holds three samples in flight. `in_ready` falls only when all three stages are full and the output is stalled.
- `in_ready` depends combinationally on `out_ready`.

Top module: `qcd_downconverter`

## Requirements
- R1: Every accepted input sample yields exactly one output transfer, in acceptance order. No output is ever presented without a matching accepted sample.
- R2: Let n count accepted samples from 0 after reset, and treat x[m] = 0 for m < 0. Let C(m) = round(2047·cos(2π·4·m/19)) and S(m) = round(2047·sin(2π·4·m/19)), rounded half away from zero. The correlator values are I[n] = Σ_{k=0..18} x[n−k]·C(n−k) and Q[n] = Σ_{k=0..18} x[n−k]·S(n−k).
- R3: `out_i` for sample n equals Σ_{j=0..18} I[n−j], and `out_q` likewise with Q, where I[m] = Q[m] = 0 for m < 0. The sums are exact, unscaled, and 33-bit two's complement.
- R4: With `out_ready` held high and the pipeline empty, take a sample accepted at rising edge t. Its result shows `out_valid` high just after edge t+2, and `out_valid` stays low after edges t and t+1.
- R5: When `out_valid` is high and `out_ready` is low, `out_valid`, `out_i` and `out_q` hold. From an empty pipeline with `out_ready` low, exactly three samples are accepted before `in_ready` falls.
- R6: Cycles in which no sample is accepted leave the results unchanged. The values depend only on the sequence of accepted samples. An idle input with an empty pipeline keeps `out_valid` low.
- R7: During and right after reset, `out_valid` is 0 and `in_ready` is 1. Reset clears the window and the running sums, and restarts the phase count n at 0.
- R8: Feed a steady carrier x[m] = round(1500·cos(2π·4·m/19 + φ)). Once the window and the running sum are full:
  - for φ = 0, `out_i` is large and positive and `out_q` is near zero;
  - for φ = π/2, `out_q` is large and negative and `out_i` is near zero;
  - for φ = π, `out_i` is large and negative.
- R9: Full-scale inputs (−2048 and +2047) give results that match R2 and R3 exactly, with no wrap in any stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | An I/Q result is presented |
| out_ready | input | 1 | Downstream accepts the presented result |
| out_i | output | 33 | Signed in-phase result |
| out_q | output | 33 | Signed quadrature result |

## Verification
The bench builds the block with its default parameters:
- 12-bit samples and 12-bit references;
- a 19-tap window holding four carrier periods;
- a 19-point running sum.

With these values, a −2048/+2047 pattern chosen against the reference signs drives the correlator close to its bound, so any narrowing of the 28-bit or 33-bit stages shows up as a mismatch. The exact four-period span means a steady carrier at 4/19 of the sample rate yields a settled, phase-dependent I/Q pair, after 37 samples, that can be compared against fixed thresholds. A three-stage pipeline is short enough that the back-pressure fill level and the two-edge latency can be observed cycle by cycle.

// File: rtl/qcd_pkg.sv
`timescale 1ns/1ps
package qcd_pkg;

  localparam real QCD_PI = 3.14159265358979323846;

  // Odd power series for sine; argument must lie within [-pi, pi].
  function automatic real qcd_sine(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 14; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Reference value for sample index idx (may be negative).
  // cos_arm selects cosine (I arm) or sine (Q arm); rounding is half away from zero.
  function automatic int qcd_ref(input int taps, input int cycles, input int amp,
                                 input int idx, input bit cos_arm);
    int  ph;
    real ang;
    real val;
    ph  = ((cycles * idx) % taps + taps) % taps;
    ang = 2.0 * QCD_PI * real'(ph) / real'(taps);
    if (cos_arm) ang = ang + QCD_PI / 2.0;
    if (ang > QCD_PI) ang = ang - 2.0 * QCD_PI;
    val = real'(amp) * qcd_sine(ang);
    if (val >= 0.0) return $rtoi(val + 0.5);
    return $rtoi(val - 0.5);
  endfunction

endpackage

// File: rtl/qcd_window.sv
`timescale 1ns/1ps
// Sample window plus circulating cosine/sine reference rings.
// Both shift by one tap on each accepted sample, so tap k always pairs
// sample x[n-k] with the reference value of its own arrival phase.
module qcd_window #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int TAPS     = 19,
  parameter int CYCLES   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       win_valid,
  input  logic                       win_ready,
  output logic signed [SAMPLE_W-1:0] win [TAPS],
  output logic signed [COEF_W-1:0]   ref_c [TAPS],
  output logic signed [COEF_W-1:0]   ref_s [TAPS]
);
  localparam int AMP = (1 << (COEF_W - 1)) - 1;

  logic take;

  assign in_ready = !win_valid || win_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_valid <= 1'b0;
    else if (in_ready) win_valid <= in_valid;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    // Reset value corresponds to phase index n = -1, so the first accepted
    // sample lines up with phase 0 once the ring has rotated once.
    localparam logic signed [COEF_W-1:0] C_RST =
      COEF_W'(qcd_pkg::qcd_ref(TAPS, CYCLES, AMP, -1 - k, 1'b1));
    localparam logic signed [COEF_W-1:0] S_RST =
      COEF_W'(qcd_pkg::qcd_ref(TAPS, CYCLES, AMP, -1 - k, 1'b0));
    localparam int SRC = (k + TAPS - 1) % TAPS;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_c[k] <= C_RST;
        ref_s[k] <= S_RST;
      end else if (take) begin
        ref_c[k] <= ref_c[SRC];
        ref_s[k] <= ref_s[SRC];
      end
    end

    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win[k] <= '0;
        else if (take) win[k] <= in_sample;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win[k] <= '0;
        else if (take) win[k] <= win[k-1];
      end
    end
  end

  AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(win[0]) && $stable(win[TAPS-1]) && $stable(ref_c[0]) && $stable(ref_s[0])) // R6
    else $error("window moved without an accepted sample");

endmodule

// File: rtl/qcd_correlator.sv
`timescale 1ns/1ps
// Parallel 2 x TAPS multiply-accumulate over the window, one register stage.
module qcd_correlator #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int TAPS     = 19,
  parameter int CORR_W   = 28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_valid,
  output logic                       win_ready,
  input  logic signed [SAMPLE_W-1:0] win [TAPS],
  input  logic signed [COEF_W-1:0]   ref_c [TAPS],
  input  logic signed [COEF_W-1:0]   ref_s [TAPS],
  output logic                       corr_valid,
  input  logic                       corr_ready,
  output logic signed [CORR_W-1:0]   corr_i,
  output logic signed [CORR_W-1:0]   corr_q
);
  localparam longint AMP   = (longint'(1) << (COEF_W - 1)) - 1;
  localparam longint BOUND = longint'(TAPS) * (longint'(1) << (SAMPLE_W - 1)) * AMP;

  logic signed [CORR_W-1:0] sum_i;
  logic signed [CORR_W-1:0] sum_q;

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_i = sum_i + CORR_W'(win[k]) * CORR_W'(ref_c[k]);
      sum_q = sum_q + CORR_W'(win[k]) * CORR_W'(ref_s[k]);
    end
  end

  assign win_ready = !corr_valid || corr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_valid <= 1'b0;
      corr_i     <= '0;
      corr_q     <= '0;
    end else if (win_ready) begin
      corr_valid <= win_valid;
      if (win_valid) begin
        corr_i <= sum_i;
        corr_q <= sum_q;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> (longint'(corr_i) <= BOUND) && (longint'(corr_i) >= -BOUND) &&
                   (longint'(corr_q) <= BOUND) && (longint'(corr_q) >= -BOUND)) // R9
    else $error("correlator value beyond its arithmetic bound");

endmodule

// File: rtl/qcd_boxcar.sv
`timescale 1ns/1ps
// One arm of the running sum: history of the last AVG_LEN correlator values
// and an exact accumulator updated by add-newest / subtract-oldest.
module qcd_boxcar #(
  parameter int CORR_W  = 28,
  parameter int AVG_LEN = 19,
  parameter int OUT_W   = 33
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     advance,
  input  logic signed [CORR_W-1:0] din,
  output logic signed [OUT_W-1:0]  sum
);
  logic signed [CORR_W-1:0] hist [AVG_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      for (int j = 0; j < AVG_LEN; j++) hist[j] <= '0;
    end else if (advance) begin
      sum     <= sum + OUT_W'(din) - OUT_W'(hist[AVG_LEN-1]);
      hist[0] <= din;
      for (int j = 1; j < AVG_LEN; j++) hist[j] <= hist[j-1];
    end
  end

  AST_SUM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(sum)) // R6
    else $error("running sum moved without a new correlator value");

endmodule

// File: rtl/qcd_downconverter.sv
`timescale 1ns/1ps
module qcd_downconverter #(
  parameter  int SAMPLE_W = 12,
  parameter  int COEF_W   = 12,
  parameter  int TAPS     = 19,
  parameter  int CYCLES   = 4,
  parameter  int AVG_LEN  = 19,
  localparam int CORR_W   = SAMPLE_W + COEF_W - 1 + $clog2(TAPS),
  localparam int OUT_W    = CORR_W + $clog2(AVG_LEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [OUT_W-1:0]    out_i,
  output logic signed [OUT_W-1:0]    out_q
);
  localparam int ARMS   = 2;
  localparam int STAGES = 3;

  logic                       win_valid;
  logic                       win_ready;
  logic signed [SAMPLE_W-1:0] win   [TAPS];
  logic signed [COEF_W-1:0]   ref_c [TAPS];
  logic signed [COEF_W-1:0]   ref_s [TAPS];
  logic                       corr_valid;
  logic                       corr_ready;
  logic signed [CORR_W-1:0]   corr_i;
  logic signed [CORR_W-1:0]   corr_q;
  logic signed [CORR_W-1:0]   corr_arm [ARMS];
  logic signed [OUT_W-1:0]    sum_arm  [ARMS];
  logic                       advance;

  qcd_window #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .CYCLES(CYCLES)
  ) u_window (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .win_valid(win_valid), .win_ready(win_ready),
    .win(win), .ref_c(ref_c), .ref_s(ref_s)
  );

  qcd_correlator #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .CORR_W(CORR_W)
  ) u_corr (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_ready(win_ready),
    .win(win), .ref_c(ref_c), .ref_s(ref_s),
    .corr_valid(corr_valid), .corr_ready(corr_ready),
    .corr_i(corr_i), .corr_q(corr_q)
  );

  assign corr_ready  = !out_valid || out_ready;
  assign advance     = corr_valid && corr_ready;
  assign corr_arm[0] = corr_i;
  assign corr_arm[1] = corr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (corr_ready) out_valid <= corr_valid;
  end

  for (genvar a = 0; a < ARMS; a++) begin : g_arm
    qcd_boxcar #(
      .CORR_W(CORR_W), .AVG_LEN(AVG_LEN), .OUT_W(OUT_W)
    ) u_box (
      .clk(clk), .rst_n(rst_n), .advance(advance),
      .din(corr_arm[a]), .sum(sum_arm[a])
    );
  end

  assign out_i = sum_arm[0];
  assign out_q = sum_arm[1];

  // Occupancy of the pipeline, used only by the checks below.
  logic       in_fire;
  logic       out_fire;
  logic [2:0] occ;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 3'(in_fire) - 3'(out_fire);
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'(STAGES)) // R1
    else $error("more samples in flight than stages");

  AST_NO_ORPHAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != 3'd0) // R1
    else $error("result presented with no sample in flight");

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q)) // R5
    else $error("stalled result changed");

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> occ == 3'(STAGES) && !out_ready) // R5
    else $error("input refused while space remained");

endmodule

// File: tb/qcd_downconverter_tb.sv
`timescale 1ns/1ps
module qcd_downconverter_tb;
  localparam int     SW      = 12;
  localparam int     OW      = 33;
  localparam int     NT      = 19;
  localparam int     NCYC    = 4;
  localparam int     NAVG    = 19;
  localparam int     AMPL    = 2047;
  localparam int     MAXS    = 4096;
  localparam real    TB_PI   = 3.14159265358979323846;
  localparam longint BIG     = 400000000;
  localparam longint SMALL   = 20000000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [SW-1:0] in_sample = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [OW-1:0] out_i;
  logic signed [OW-1:0] out_q;

  always #2.5 clk = ~clk;

  qcd_downconverter #(
    .SAMPLE_W(SW), .COEF_W(12), .TAPS(NT), .CYCLES(NCYC), .AVG_LEN(NAVG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q)
  );

  int          n_tests = 0;
  int          n_fail  = 0;
  int          n_in    = 0;
  int          n_out   = 0;
  longint      xs    [MAXS];
  longint      ci    [MAXS];
  longint      cq    [MAXS];
  longint      ei    [MAXS];
  longint      eq    [MAXS];
  longint      last_i = 0;
  longint      last_q = 0;
  int unsigned seed   = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint lo_val(input longint m, input bit cos_arm);
    longint p;
    real    a;
    real    v;
    p = ((NCYC * m) % NT + NT) % NT;
    a = 2.0 * TB_PI * real'(p) / real'(NT);
    v = real'(AMPL) * (cos_arm ? $cos(a) : $sin(a));
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return longint'($rtoi(v - 0.5));
  endfunction

  function automatic longint carrier(input longint m, input real phi);
    real v;
    v = 1500.0 * $cos(2.0 * TB_PI * real'(NCYC) * real'(m) / real'(NT) + phi);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return longint'($rtoi(v - 0.5));
  endfunction

  // Reference model of R2 and R3, fed only by observed transfers.
  task automatic model_accept(input longint s);
    longint a;
    longint b;
    xs[n_in] = s;
    a = 0;
    b = 0;
    for (int k = 0; k < NT; k++)
      if (n_in - k >= 0) begin
        a += xs[n_in-k] * lo_val(n_in - k, 1'b1);
        b += xs[n_in-k] * lo_val(n_in - k, 1'b0);
      end
    ci[n_in] = a;
    cq[n_in] = b;
    a = 0;
    b = 0;
    for (int j = 0; j < NAVG; j++)
      if (n_in - j >= 0) begin
        a += ci[n_in-j];
        b += cq[n_in-j];
      end
    ei[n_in] = a;
    eq[n_in] = b;
    n_in++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (in_valid && in_ready) model_accept(longint'(in_sample));
        if (out_valid && out_ready) begin
          if (n_out >= n_in) begin
            check(1'b0, "R1", "output without accepted sample", n_out, n_in);
          end else begin
            check(longint'(out_i) == ei[n_out], "R2/R3", "out_i", longint'(out_i), ei[n_out]);
            check(longint'(out_q) == eq[n_out], "R2/R3", "out_q", longint'(out_q), eq[n_out]);
            last_i = longint'(out_i);
            last_q = longint'(out_q);
            n_out++;
          end
        end
      end
    end
  end

  task automatic push(input longint s);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = SW'(s);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int c = 0; c < 60 && n_out != n_in; c++) @(negedge clk);
    #2;
    check(n_out == n_in, "R1", "outputs delivered vs accepted", n_out, n_in);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    n_in     = 0;
    n_out    = 0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
  endtask

  task automatic test_latency();
    drain();
    push(300);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R4", "out_valid after edge t", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R4", "out_valid after edge t+1", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R4", "out_valid after edge t+2", out_valid, 1);
    drain();
  endtask

  task automatic test_impulse();
    push(1);
    for (int i = 0; i < 40; i++) push(0);
    push(-1);
    for (int i = 0; i < 20; i++) push(0);
    drain();
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      push(longint'(int'((seed >> 16) % 4096)) - 2048);
      if (i % 3 == 1) idle(1 + i % 4);
    end
    drain();
    repeat (5) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R6", "out_valid on idle input", out_valid, 0);
  endtask

  task automatic test_backpressure();
    int     accepted;
    longint hold_i;
    longint hold_q;
    drain();
    @(negedge clk);
    out_ready = 1'b0;
    accepted  = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = SW'(100 * (accepted + 1) - 777);
      #1;
      if (in_ready) accepted++;
    end
    check(accepted == 3, "R5", "samples absorbed while stalled", accepted, 3);
    check(out_valid == 1'b1, "R5", "out_valid under stall", out_valid, 1);
    hold_i = longint'(out_i);
    hold_q = longint'(out_q);
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R5", "out_valid held", out_valid, 1);
    check(longint'(out_i) == hold_i, "R5", "out_i held", longint'(out_i), hold_i);
    check(longint'(out_q) == hold_q, "R5", "out_q held", longint'(out_q), hold_q);
    drain();
  endtask

  task automatic run_carrier(input real phi);
    int base;
    base = n_in;
    for (int i = 0; i < 40; i++) push(carrier(base + i, phi));
    drain();
  endtask

  task automatic test_carrier();
    run_carrier(0.0);
    check(last_i > BIG, "R8", "I for cosine phase", last_i, BIG);
    check(last_q < SMALL && last_q > -SMALL, "R8", "Q for cosine phase", last_q, 0);
    run_carrier(TB_PI / 2.0);
    check(last_q < -BIG, "R8", "Q for sine phase", last_q, -BIG);
    check(last_i < SMALL && last_i > -SMALL, "R8", "I for sine phase", last_i, 0);
    run_carrier(TB_PI);
    check(last_i < -BIG, "R8", "I for inverted phase", last_i, -BIG);
  endtask

  task automatic test_fullscale();
    int base;
    base = n_in;
    for (int i = 0; i < 45; i++)
      push(lo_val(base + i, 1'b1) < 0 ? -2048 : 2047);
    drain();
    check(last_i > 0, "R9", "full-scale I sign", last_i, 1);
    for (int i = 0; i < 45; i++) push(-2048);
    drain();
  endtask

  task automatic test_midreset();
    for (int i = 0; i < 10; i++) push(2000 - 300 * i);
    do_reset();
    for (int i = 0; i < 25; i++) push(5 * i - 60);
    drain();
    check(n_in == 25, "R7", "phase count restarted", n_in, 25);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    test_latency();
    test_impulse();
    test_gaps();
    test_backpressure();
    test_carrier();
    test_fullscale();
    test_midreset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule